// File: doc/BRIEF.md
# PHY Link and Duplex Resolver

This block runs on top of an MDIO master and turns the link state of a single PHY into two mode bits of a MAC mode word. A one-cycle `start` pulse latches a PHY address. The block then asks the MDIO master for the PHY status register, followed by the link-partner ability register. From these two values it decides whether the transceiver is present and whether the link is up. It then resolves the speed class and the duplex.

The link bit in the status register latches low. For that reason a clear link bit causes one more status read before the block reports the link as down. The abilities shared by both ends are found by a bitwise AND of the partner ability word and the local advertisement word. From that result the block sets or clears a transmit-threshold bit and a full-duplex bit in a stored mode word. The mode word is written, and a one-cycle MAC restart pulse is sent, only when one of these bits actually changes value.

Each run ends with a one-cycle `done` pulse that carries a 2-bit result code. The `changed` flag is high in that same cycle when the mode word was updated. The block handles only one run at a time.

Top module: `phy_link_resolver`

## Requirements
- R1: After a `start` pulse while idle, the block latches `phy_addr` and requests a read of register 1 (status). It later requests register 5 (partner ability). Both requests carry the latched address. A request keeps `mreq_valid` high, with a stable register and address, until `mreq_ready` is seen.
- R2: If the first status read returns 0xFFFF, the block reports result 3 (missing). It makes no ability read, issues no restart and leaves the mode word unchanged.
- R3: If bit 2 (link) of the status value is clear, the status register is read a second time. If bit 2 is still clear, the result is 2 (no link), with no ability read, no restart and no change to the mode word.
- R4: If the second status read shows bit 2 set, the block goes on to the ability read and resolves normally.
- R5: The negotiated ability is partner ability AND `adv_word`. If any of bits 9, 8 or 7 of that value is set, mode bit 21 (transmit threshold) is cleared. Otherwise it is set.
- R6: Mode bit 9 (full duplex) is set when any one of these holds:
  - `dup_lock` is high;
  - negotiated bit 8 is set;
  - among negotiated bits 8..5, bit 6 is the only one set.

  In every other case mode bit 9 is cleared. All other mode bits are kept.
- R7: If the resolved mode word differs from the stored one, the stored word is replaced. In the same cycle as `done`, `mac_restart` pulses for one cycle, the result is 1 (changed) and `changed` is high.
- R8: If the resolved word equals the stored one, the result is 0 (ok), `changed` and `mac_restart` stay low and the mode word holds.
- R9: A `start` pulse that arrives while a run is in progress is ignored: it causes no extra MDIO request after that run ends.
- R10: After reset the mode word is 0 and `done`, `mac_restart` and `mreq_valid` are low. `done` is high for exactly one cycle per run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a resolve run when idle |
| phy_addr | input | 5 | PHY address latched at start |
| adv_word | input | 16 | Locally advertised ability word |
| dup_lock | input | 1 | Forces full duplex |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 2 | 0 ok, 1 changed, 2 no link, 3 missing |
| changed | output | 1 | High with done when the mode word was rewritten |
| mreq_valid | output | 1 | MDIO read request valid |
| mreq_ready | input | 1 | MDIO master accepts the request |
| mreq_phy | output | 5 | PHY address of the request |
| mreq_reg | output | 5 | Register number of the request |
| mrsp_valid | input | 1 | Read data valid |
| mrsp_data | input | 16 | Read data |
| mode_word | output | 32 | Stored MAC mode word |
| mac_restart | output | 1 | One-cycle MAC restart pulse |

## Verification
The bound checker watches every cycle for the following:
- each request is held until accepted and names only register 1 or 5;
- `done` lasts exactly one cycle;
- a missing, no-link or unchanged result never comes with a restart;
- the mode word moves only in a restart cycle, and in that cycle it really differs from its old value.

Other properties can be shown only by the bench's scenarios with its scripted PHY model:
- the exact resolved threshold and duplex bits for each mix of abilities;
- the single status re-read on a latched-low link;
- the absence of an ability read on the early exits;
- the rejection of a second start while a run is in progress.

// File: rtl/plr_pkg.sv
package plr_pkg;

   typedef enum logic [1:0] {
      RES_OK      = 2'd0,
      RES_CHANGED = 2'd1,
      RES_NOLINK  = 2'd2,
      RES_MISSING = 2'd3
   } res_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RD_ST,
      S_WT_ST,
      S_RD_LP,
      S_WT_LP,
      S_APPLY
   } seq_st_e;

   typedef enum logic [1:0] {
      FIN_MISSING,
      FIN_NOLINK,
      FIN_RESOLVED
   } fin_e;

   // ability bit positions inside the status/ability words
   localparam int ABIL_T4   = 9;
   localparam int ABIL_TXFD = 8;
   localparam int ABIL_TXHD = 7;
   localparam int ABIL_TFD  = 6;
   localparam int ABIL_THD  = 5;

endpackage

// File: rtl/plr_seq.sv
module plr_seq #(
   parameter int ADDR_W   = 5,
   parameter int RADDR_W  = 5,
   parameter int REG_W    = 16,
   parameter int STAT_REG = 1,
   parameter int LPA_REG  = 5,
   parameter int LINK_BIT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ADDR_W-1:0]  phy_addr,
   output logic               mreq_valid,
   input  logic               mreq_ready,
   output logic [ADDR_W-1:0]  mreq_phy,
   output logic [RADDR_W-1:0] mreq_reg,
   input  logic               mrsp_valid,
   input  logic [REG_W-1:0]   mrsp_data,
   output logic               fin_valid,
   output plr_pkg::fin_e      fin_kind,
   output logic [REG_W-1:0]   lpa_q
);
   import plr_pkg::*;

   localparam logic [REG_W-1:0] ABSENT = '1;

   seq_st_e           st;
   logic              retry_q;
   logic [ADDR_W-1:0] addr_q;
   logic              absent;
   logic              link_up;

   assign absent  = (mrsp_data == ABSENT);
   assign link_up = mrsp_data[LINK_BIT];

   assign mreq_valid = (st == S_RD_ST) || (st == S_RD_LP);
   assign mreq_reg   = (st == S_RD_LP) ? RADDR_W'(LPA_REG) : RADDR_W'(STAT_REG);
   assign mreq_phy   = addr_q;

   always_comb begin
      fin_valid = 1'b0;
      fin_kind  = FIN_RESOLVED;
      if (st == S_WT_ST && mrsp_valid) begin
         if (!retry_q && absent) begin
            fin_valid = 1'b1;
            fin_kind  = FIN_MISSING;
         end else if (!link_up && retry_q) begin
            fin_valid = 1'b1;
            fin_kind  = FIN_NOLINK;
         end
      end else if (st == S_APPLY) begin
         fin_valid = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         retry_q <= 1'b0;
         addr_q  <= '0;
         lpa_q   <= '0;
      end else begin
         case (st)
            S_IDLE: begin
               if (start) begin
                  addr_q  <= phy_addr;
                  retry_q <= 1'b0;
                  st      <= S_RD_ST;
               end
            end
            S_RD_ST: if (mreq_ready) st <= S_WT_ST;
            S_WT_ST: begin
               if (mrsp_valid) begin
                  if (!retry_q && absent) begin
                     st <= S_IDLE;
                  end else if (!link_up) begin
                     if (retry_q) begin
                        st <= S_IDLE;
                     end else begin
                        retry_q <= 1'b1;
                        st      <= S_RD_ST;
                     end
                  end else begin
                     st <= S_RD_LP;
                  end
               end
            end
            S_RD_LP: if (mreq_ready) st <= S_WT_LP;
            S_WT_LP: begin
               if (mrsp_valid) begin
                  lpa_q <= mrsp_data;
                  st    <= S_APPLY;
               end
            end
            S_APPLY: st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/plr_resolve.sv
module plr_resolve #(
   parameter int REG_W    = 16,
   parameter int MODE_W   = 32,
   parameter int THR_BIT  = 21,
   parameter int FDX_BIT  = 9,
   parameter bit COUNT_T4 = 1'b1
) (
   input  logic [REG_W-1:0]  lpa,
   input  logic [REG_W-1:0]  adv,
   input  logic              lock,
   input  logic [MODE_W-1:0] cur_mode,
   output logic [MODE_W-1:0] nxt_mode,
   output logic              differs
);
   import plr_pkg::*;

   logic [REG_W-1:0] neg;
   logic             fast;
   logic             fdx;
   logic             unused_bits;

   assign neg = lpa & adv;
   assign unused_bits = ^{neg[REG_W-1:ABIL_T4+1], neg[ABIL_T4], neg[ABIL_THD-1:0]};

   if (COUNT_T4) begin : g_t4
      assign fast = neg[ABIL_T4] | neg[ABIL_TXFD] | neg[ABIL_TXHD];
   end else begin : g_no_t4
      assign fast = neg[ABIL_TXFD] | neg[ABIL_TXHD];
   end

   assign fdx = lock | neg[ABIL_TXFD] | (neg[ABIL_TXFD:ABIL_THD] == 4'b0010);

   always_comb begin
      nxt_mode          = cur_mode;
      nxt_mode[THR_BIT] = ~fast;
      nxt_mode[FDX_BIT] = fdx;
   end

   assign differs = (nxt_mode != cur_mode);

endmodule

// File: rtl/plr_mode_reg.sv
module plr_mode_reg #(
   parameter int                MODE_W    = 32,
   parameter logic [MODE_W-1:0] MODE_INIT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fin_valid,
   input  plr_pkg::fin_e     fin_kind,
   input  logic [MODE_W-1:0] nxt_mode,
   input  logic              differs,
   output logic [MODE_W-1:0] mode_word,
   output logic              done,
   output logic [1:0]        result,
   output logic              mac_restart
);
   import plr_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_word   <= MODE_INIT;
         done        <= 1'b0;
         result      <= RES_OK;
         mac_restart <= 1'b0;
      end else begin
         done        <= fin_valid;
         mac_restart <= 1'b0;
         if (fin_valid) begin
            case (fin_kind)
               FIN_MISSING: result <= RES_MISSING;
               FIN_NOLINK:  result <= RES_NOLINK;
               default: begin
                  if (differs) begin
                     mode_word   <= nxt_mode;
                     mac_restart <= 1'b1;
                     result      <= RES_CHANGED;
                  end else begin
                     result <= RES_OK;
                  end
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/phy_link_resolver.sv
module phy_link_resolver #(
   parameter int                ADDR_W    = 5,
   parameter int                RADDR_W   = 5,
   parameter int                REG_W     = 16,
   parameter int                MODE_W    = 32,
   parameter int                STAT_REG  = 1,
   parameter int                LPA_REG   = 5,
   parameter int                LINK_BIT  = 2,
   parameter int                THR_BIT   = 21,
   parameter int                FDX_BIT   = 9,
   parameter bit                COUNT_T4  = 1'b1,
   parameter logic [MODE_W-1:0] MODE_INIT = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ADDR_W-1:0]  phy_addr,
   input  logic [REG_W-1:0]   adv_word,
   input  logic               dup_lock,
   output logic               done,
   output logic [1:0]         result,
   output logic               changed,
   output logic               mreq_valid,
   input  logic               mreq_ready,
   output logic [ADDR_W-1:0]  mreq_phy,
   output logic [RADDR_W-1:0] mreq_reg,
   input  logic               mrsp_valid,
   input  logic [REG_W-1:0]   mrsp_data,
   output logic [MODE_W-1:0]  mode_word,
   output logic               mac_restart
);
   import plr_pkg::*;

   if (REG_W < 16) begin : g_bad_regw
      $error("REG_W must be at least 16");
   end
   if (THR_BIT >= MODE_W || FDX_BIT >= MODE_W) begin : g_bad_bitpos
      $error("mode bit position outside MODE_W");
   end
   if (THR_BIT == FDX_BIT) begin : g_bad_overlap
      $error("THR_BIT and FDX_BIT must differ");
   end
   if (STAT_REG == LPA_REG || STAT_REG >= (1 << RADDR_W) || LPA_REG >= (1 << RADDR_W)) begin : g_bad_reg
      $error("register numbers invalid");
   end
   if (LINK_BIT >= REG_W) begin : g_bad_link
      $error("LINK_BIT outside REG_W");
   end

   logic              fin_valid;
   fin_e              fin_kind;
   logic [REG_W-1:0]  lpa_q;
   logic [MODE_W-1:0] nxt_mode;
   logic              differs;

   plr_seq #(
      .ADDR_W(ADDR_W), .RADDR_W(RADDR_W), .REG_W(REG_W),
      .STAT_REG(STAT_REG), .LPA_REG(LPA_REG), .LINK_BIT(LINK_BIT)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .phy_addr(phy_addr),
      .mreq_valid(mreq_valid), .mreq_ready(mreq_ready),
      .mreq_phy(mreq_phy), .mreq_reg(mreq_reg),
      .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data),
      .fin_valid(fin_valid), .fin_kind(fin_kind), .lpa_q(lpa_q)
   );

   plr_resolve #(
      .REG_W(REG_W), .MODE_W(MODE_W), .THR_BIT(THR_BIT),
      .FDX_BIT(FDX_BIT), .COUNT_T4(COUNT_T4)
   ) u_resolve (
      .lpa(lpa_q), .adv(adv_word), .lock(dup_lock), .cur_mode(mode_word),
      .nxt_mode(nxt_mode), .differs(differs)
   );

   plr_mode_reg #(
      .MODE_W(MODE_W), .MODE_INIT(MODE_INIT)
   ) u_mode (
      .clk(clk), .rst_n(rst_n), .fin_valid(fin_valid), .fin_kind(fin_kind),
      .nxt_mode(nxt_mode), .differs(differs), .mode_word(mode_word),
      .done(done), .result(result), .mac_restart(mac_restart)
   );

   assign changed = done && (result == RES_CHANGED);

endmodule

// File: rtl/plr_checker.sv
module plr_checker #(
   parameter int ADDR_W   = 5,
   parameter int RADDR_W  = 5,
   parameter int MODE_W   = 32,
   parameter int STAT_REG = 1,
   parameter int LPA_REG  = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               done,
   input logic [1:0]         result,
   input logic               changed,
   input logic               mreq_valid,
   input logic               mreq_ready,
   input logic [ADDR_W-1:0]  mreq_phy,
   input logic [RADDR_W-1:0] mreq_reg,
   input logic [MODE_W-1:0]  mode_word,
   input logic               mac_restart
);
   import plr_pkg::*;

   // R1: request held with stable fields until accepted
   p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_reg) && $stable(mreq_phy));

   // R1: only status or ability register is requested
   p_req_reg_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mreq_valid |-> (mreq_reg == RADDR_W'(STAT_REG) || mreq_reg == RADDR_W'(LPA_REG)));

   p_missing_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done && result == RES_MISSING |-> !mac_restart && !changed);

   p_nolink_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done && result == RES_NOLINK |-> !mac_restart && !changed);

   p_restart_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mac_restart |-> done && changed && (mode_word != $past(mode_word)));

   p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !mac_restart |-> $stable(mode_word));

   p_ok_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done && result == RES_OK |-> !mac_restart && !changed);

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

bind phy_link_resolver plr_checker #(
   .ADDR_W(ADDR_W), .RADDR_W(RADDR_W), .MODE_W(MODE_W),
   .STAT_REG(STAT_REG), .LPA_REG(LPA_REG)
) u_plr_checker (
   .clk(clk), .rst_n(rst_n), .done(done), .result(result), .changed(changed),
   .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_phy(mreq_phy),
   .mreq_reg(mreq_reg), .mode_word(mode_word), .mac_restart(mac_restart)
);

// File: tb/phy_link_resolver_test.sv
module phy_link_resolver_test;

   localparam int PERIOD = 10;
   localparam int NVEC   = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [4:0]  phy_addr = '0;
   logic [15:0] adv_word = '0;
   logic        dup_lock = 1'b0;
   logic        done;
   logic [1:0]  result;
   logic        changed;
   logic        mreq_valid;
   logic        mreq_ready = 1'b1;
   logic [4:0]  mreq_phy;
   logic [4:0]  mreq_reg;
   logic        mrsp_valid = 1'b0;
   logic [15:0] mrsp_data = '0;
   logic [31:0] mode_word;
   logic        mac_restart;

   int n_tests = 0;
   int n_fail  = 0;
   logic [31:0] exp_mode = '0;

   always #(PERIOD/2) clk = ~clk;

   phy_link_resolver uut (
      .clk(clk), .rst_n(rst_n), .start(start), .phy_addr(phy_addr),
      .adv_word(adv_word), .dup_lock(dup_lock), .done(done), .result(result),
      .changed(changed), .mreq_valid(mreq_valid), .mreq_ready(mreq_ready),
      .mreq_phy(mreq_phy), .mreq_reg(mreq_reg), .mrsp_valid(mrsp_valid),
      .mrsp_data(mrsp_data), .mode_word(mode_word), .mac_restart(mac_restart)
   );

   // {status0, status1, partner, advert, lock, expected result}
   localparam logic [66:0] VEC [NVEC] = '{
      {16'h782D, 16'h782D, 16'h41E1, 16'h01E1, 1'b0, 2'd1},
      {16'h782D, 16'h782D, 16'h41E1, 16'h01E1, 1'b0, 2'd0},
      {16'h782D, 16'h782D, 16'h0021, 16'h01E1, 1'b0, 2'd1},
      {16'h782D, 16'h782D, 16'h0041, 16'h01E1, 1'b0, 2'd1},
      {16'h782D, 16'h782D, 16'h0061, 16'h01E1, 1'b0, 2'd1},
      {16'h782D, 16'h782D, 16'h0061, 16'h01E1, 1'b1, 2'd1},
      {16'hFFFF, 16'h782D, 16'h41E1, 16'h01E1, 1'b0, 2'd3},
      {16'h7809, 16'h782D, 16'h0081, 16'h01E1, 1'b0, 2'd1},
      {16'h7809, 16'h7809, 16'h41E1, 16'h01E1, 1'b0, 2'd2},
      {16'h782D, 16'h782D, 16'h0081, 16'h0061, 1'b0, 2'd1},
      {16'h782D, 16'h782D, 16'h0201, 16'h0201, 1'b0, 2'd1},
      {16'h782D, 16'h782D, 16'h0201, 16'h0201, 1'b0, 2'd0}
   };

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] model(input logic [31:0] cur, input logic [15:0] lpa,
                                         input logic [15:0] adv, input logic lock);
      logic [15:0] neg;
      logic [31:0] m;
      neg   = lpa & adv;
      m     = cur;
      m[21] = !(neg[9] | neg[8] | neg[7]);
      m[9]  = lock | neg[8] | (neg[8:5] == 4'b0010);
      return m;
   endfunction

   task automatic run_op(input logic [15:0] st0, input logic [15:0] st1,
                         input logic [15:0] lpa, input logic [15:0] adv,
                         input logic lock, input logic [4:0] addr,
                         input int stall, input bit poke,
                         output logic [1:0] res, output bit chg, output bit rst_seen,
                         output logic [31:0] mode, output int n_st, output int n_lp,
                         output bit addr_ok, output bit timeout);
      int stcnt = 0;
      bit poked = 1'b0;
      logic [4:0] rq;
      n_st = 0; n_lp = 0; addr_ok = 1'b1; timeout = 1'b1;
      res = '0; chg = 1'b0; rst_seen = 1'b0; mode = '0;
      @(negedge clk);
      adv_word = adv; dup_lock = lock; phy_addr = addr; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 80; c++) begin
         if (done) begin
            res = result; chg = changed; rst_seen = mac_restart; mode = mode_word;
            timeout = 1'b0;
            break;
         end
         if (mreq_valid) begin
            if (poke && !poked) begin
               start = 1'b1;
               poked = 1'b1;
            end
            if (stall > 0) begin
               mreq_ready = 1'b0;
               repeat (stall) begin
                  @(negedge clk);
                  start = 1'b0;
               end
               mreq_ready = 1'b1;
            end
            if (mreq_phy != addr) addr_ok = 1'b0;
            rq = mreq_reg;
            @(negedge clk);
            start = 1'b0;
            mrsp_valid = 1'b1;
            if (rq == 5'd1) begin
               mrsp_data = (stcnt == 0) ? st0 : st1;
               stcnt++;
               n_st++;
            end else begin
               mrsp_data = lpa;
               n_lp++;
            end
            @(negedge clk);
            mrsp_valid = 1'b0;
            mrsp_data  = '0;
         end else begin
            @(negedge clk);
         end
      end
   endtask

   task automatic do_vector(input logic [66:0] v, input logic [4:0] addr,
                            input int stall, input bit poke);
      logic [15:0] st0, st1, lpa, adv;
      logic        lock;
      logic [1:0]  exp_res, res;
      logic [31:0] mode, nm;
      bit chg, rs, aok, to;
      int nst, nlp, exp_st;
      st0 = v[66:51]; st1 = v[50:35]; lpa = v[34:19]; adv = v[18:3];
      lock = v[2]; exp_res = v[1:0];
      run_op(st0, st1, lpa, adv, lock, addr, stall, poke, res, chg, rs, mode, nst, nlp, aok, to);
      check(!to, "R10 done seen", 32'(to), 32'd0);
      check(res == exp_res, "R2/R3/R7/R8 result", 32'(res), 32'(exp_res));
      check(aok, "R1 address", 32'(aok), 32'd1);
      if (exp_res == 2'd3) begin
         check(nst == 1 && nlp == 0, "R2 reads", 32'(nst*16+nlp), 32'h10);
      end else if (exp_res == 2'd2) begin
         check(nst == 2 && nlp == 0, "R3 reads", 32'(nst*16+nlp), 32'h20);
      end else begin
         nm = model(exp_mode, lpa, adv, lock);
         exp_st = st0[2] ? 1 : 2;
         check(nst == exp_st && nlp == 1, "R1 R4 reads", 32'(nst*16+nlp), 32'(exp_st*16+1));
         check(mode == nm, "R5 R6 mode", mode, nm);
         check(chg == (nm != exp_mode), "R7 changed", 32'(chg), 32'(nm != exp_mode));
         exp_mode = nm;
      end
      check(rs == chg, "R7 R8 restart", 32'(rs), 32'(chg));
      check(mode_word == exp_mode, "R8 mode held", mode_word, exp_mode);
   endtask

   initial begin
      #(PERIOD*200000);
      n_tests++;
      n_fail++;
      $display("FAIL R10 watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check(mode_word == 32'd0, "R10 reset mode", mode_word, 32'd0);
      check(!done && !mac_restart && !mreq_valid, "R10 reset outputs",
            32'({done, mac_restart, mreq_valid}), 32'd0);

      for (int i = 0; i < NVEC; i++) begin
         do_vector(VEC[i], 5'(i + 3), 0, 1'b0);
      end

      // R1 stalled ready with R9 start poked during the run
      do_vector({16'h782D, 16'h782D, 16'h0141, 16'h01E1, 1'b0, 2'd1}, 5'd17, 3, 1'b1);
      begin
         bit extra = 1'b0;
         repeat (6) begin
            @(negedge clk);
            if (mreq_valid) extra = 1'b1;
         end
         check(!extra, "R9 start ignored while busy", 32'(extra), 32'd0);
      end

      // R2 missing while latched-low retry would not apply; mode untouched
      do_vector({16'hFFFF, 16'h0000, 16'h0021, 16'h01E1, 1'b1, 2'd3}, 5'd31, 2, 1'b0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule